// File: doc/BRIEF.md
# Multi-Master Cache Maintenance Queue Front-End

This block is the register front end through which several processors post cache maintenance commands into one shared operation queue. Every processor owns a simple register port (request, write enable, register select, write data, acknowledge, read data). All processors see the same set of command registers: mode, address, size and way mask. Only one processor at a time may write those registers. Each processor also has its own private set-result, status and primitive registers.

A processor builds a command in three steps. It first writes the mode register, which claims the right to write the shared registers. It then writes the address, size and way registers as its command needs them. Finally it reads its set-result register. That read releases the claim, and it commits the command to the queue if the queue has room. A processor that loses the claim, or finds the queue full, sees a nonzero set-result and repeats the whole sequence.

Committed commands leave the queue strictly in order. Each one is handed to a stub executor that is busy for a fixed latency and reports its fields on a small output bus. A sync primitive lets a processor stall a read until the queue has drained. A watchdog frees the claim if its holder never reads its set-result register.

Top module: `cmq_front`

## Requirements
- R1: Register selects are 0 mode, 1 address, 2 size, 3 way mask, 4 set-result, 5 status, 6 primitive. Within the mode word, bits 2:0 give the command (0 invalidate, 1 clean, 2 flush, 3 prefetch to cache, 4 prefetch to buffer, 5 touch, 6 touch zero, 7 touch dirty). Bits 18:17 give the region (0 range, 1 all, 2 way), bits 22:21 give the target (0 LRU data, 1 LRU instruction, 2 by way), and bit 15 requests completion notice. The executor reports these fields on ex_cmd, ex_region and ex_target.
- R2: When nobody holds the claim, the first processor to write the mode register takes it. If several processors write the mode register in the same cycle, the lowest-numbered one wins. The holder keeps the claim until it reads its own set-result register.
- R3: A write to the mode, address, size or way register from a processor that does not hold the claim changes nothing and sets that processor's error flag. The processor's next set-result read returns bit 0 = 1 and clears the flag.
- R4: When the holder reads set-result and the queue is full, the read returns bit 1 = 1 and no command is enqueued. When the queue has room, the read returns 0 and the command is enqueued. In both cases the claim is released.
- R5: Commands execute one at a time, in the order they were accepted. Each one is busy for EXEC_LAT cycles, so two consecutive ex_start pulses are at least EXEC_LAT+1 cycles apart.
- R6: The address and size reach the executor only for region 0; for any other region they are zero. The way mask reaches the executor only for target 2; for any other target it is zero.
- R7: Each processor's status register reads bit 0 = 1 while one of its commands is queued or executing, and bit 1 = its pending error flag.
- R8: Status bit 2 is set when a command from that processor that requested notice finishes. Writing status with bit 2 = 1 clears it. If a set and a clear land in the same cycle, the set wins.
- R9: After a processor writes code 8 to its primitive register, its next primitive read is not acknowledged until the queue is empty and the executor is idle. After code 9, that read waits only while a prefetch-to-buffer command (command 4) is queued or executing.
- R10: If the holder neither reads set-result nor rewrites the mode register for WDOG_CYC cycles, the claim is released and the holder's error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | N_CPU | Per-processor access request |
| cpu_we | input | N_CPU | Per-processor write enable |
| cpu_sel | input | 3*N_CPU | Per-processor register select |
| cpu_wdata | input | 32*N_CPU | Per-processor write data |
| cpu_ack | output | N_CPU | Access accepted this cycle |
| cpu_rdata | output | 32*N_CPU | Read data, valid while acknowledged |
| ex_start | output | 1 | Executor begins a command (one-cycle pulse) |
| ex_cpu | output | clog2(N_CPU) | Issuing processor of the current command |
| ex_cmd | output | 3 | Command code |
| ex_region | output | 2 | Region selector |
| ex_target | output | 2 | Target selector |
| ex_addr | output | AW | Start address (range commands only) |
| ex_size | output | AW | Size (range commands only) |
| ex_ways | output | WAYS | Way mask (way-targeted commands only) |
| ex_done | output | 1 | Executor finishes the current command |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the executor raising a processor's completion flag and that processor's write that clears the flag. The bench watches for ex_start, then counts EXEC_LAT-2 further cycles so that the clear write is accepted on exactly the finishing edge. A later status read must still show bit 2 set.

The second pair is two processors writing the mode register in the same cycle. Both writes are driven on one edge. The lower-numbered processor must commit normally, and the other must read an error from its set-result register.

// File: rtl/cmq_pkg.sv
`timescale 1ns/1ps
package cmq_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    SEL_MODE   = 3'd0,
    SEL_ADDR   = 3'd1,
    SEL_SIZE   = 3'd2,
    SEL_WAYS   = 3'd3,
    SEL_SETRES = 3'd4,
    SEL_STAT   = 3'd5,
    SEL_PRIM   = 3'd6
  } sel_e;

  localparam int       NOTE_BIT   = 15;
  localparam logic [1:0] RGN_RANGE = 2'd0;
  localparam logic [1:0] TGT_WAY   = 2'd2;
  localparam logic [2:0] CMD_PFBUF = 3'd4;
  localparam logic [3:0] PRIM_SYNC = 4'h8;
  localparam logic [3:0] PRIM_PFB  = 4'h9;

  function automatic logic [2:0] f_cmd(input logic [DW-1:0] m);
    return m[2:0];
  endfunction

  function automatic logic [1:0] f_region(input logic [DW-1:0] m);
    return m[18:17];
  endfunction

  function automatic logic [1:0] f_target(input logic [DW-1:0] m);
    return m[22:21];
  endfunction

  function automatic logic f_note(input logic [DW-1:0] m);
    return m[NOTE_BIT];
  endfunction

  // set-result word: bit1 queue full, bit0 registration error
  function automatic logic [DW-1:0] f_setres(input logic full, input logic err);
    return {{(DW-2){1'b0}}, full, err};
  endfunction
endpackage

// File: rtl/cmq_arbiter.sv
`timescale 1ns/1ps
module cmq_arbiter #(
  parameter int N_CPU    = 2,
  parameter int AW       = 32,
  parameter int WAYS     = 8,
  parameter int WDOG_CYC = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [N_CPU-1:0]                       mode_wr,
  input  logic [N_CPU-1:0]                       addr_wr,
  input  logic [N_CPU-1:0]                       size_wr,
  input  logic [N_CPU-1:0]                       ways_wr,
  input  logic [N_CPU-1:0]                       setres_rd,
  input  logic [N_CPU*32-1:0]                    wdata,
  output logic                                   own_vld,
  output logic [$clog2(N_CPU>1?N_CPU:2)-1:0]     own_id,
  output logic [31:0]                            mode_q,
  output logic [AW-1:0]                          addr_q,
  output logic [AW-1:0]                          size_q,
  output logic [WAYS-1:0]                        ways_q,
  output logic [N_CPU-1:0]                       fail_evt,
  output logic                                   commit,
  output logic                                   wd_fire
);
  localparam int CPUW = $clog2(N_CPU > 1 ? N_CPU : 2);
  localparam int WCW  = $clog2(WDOG_CYC + 1);

  logic            win_vld;
  logic [CPUW-1:0] win_id;
  logic [N_CPU-1:0] may_wr;
  logic [WCW-1:0]  wd_cnt;
  logic            own_mode_wr;

  // lowest index wins a simultaneous claim
  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    for (int i = N_CPU - 1; i >= 0; i--) begin
      if (mode_wr[i]) begin
        win_vld = 1'b1;
        win_id  = CPUW'(i);
      end
    end
  end

  for (genvar g = 0; g < N_CPU; g++) begin : g_perm
    assign may_wr[g]   = own_vld ? (own_id == CPUW'(g)) : (win_vld && win_id == CPUW'(g));
    assign fail_evt[g] = (mode_wr[g] | addr_wr[g] | size_wr[g] | ways_wr[g]) & ~may_wr[g];
  end

  assign commit      = own_vld && setres_rd[own_id];
  assign own_mode_wr = own_vld && mode_wr[own_id];
  assign wd_fire     = own_vld && !commit && !own_mode_wr && (wd_cnt == WCW'(WDOG_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_id  <= '0;
      wd_cnt  <= '0;
    end else if (!own_vld) begin
      if (win_vld) begin
        own_vld <= 1'b1;
        own_id  <= win_id;
        wd_cnt  <= '0;
      end
    end else if (commit || wd_fire) begin
      own_vld <= 1'b0;
    end else if (own_mode_wr) begin
      wd_cnt <= '0;
    end else begin
      wd_cnt <= wd_cnt + WCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      addr_q <= '0;
      size_q <= '0;
      ways_q <= '0;
    end else begin
      for (int i = 0; i < N_CPU; i++) begin
        if (may_wr[i] && mode_wr[i]) mode_q <= wdata[i*32 +: 32];
        if (may_wr[i] && addr_wr[i]) addr_q <= wdata[i*32 +: AW];
        if (may_wr[i] && size_wr[i]) size_q <= wdata[i*32 +: AW];
        if (may_wr[i] && ways_wr[i]) ways_q <= wdata[i*32 +: WAYS];
      end
    end
  end

  // R2
  claim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_vld && !commit && !wd_fire) |=> (own_vld && own_id == $past(own_id)));

  // R10
  wdog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_vld |-> (wd_cnt < WCW'(WDOG_CYC)));
endmodule

// File: rtl/cmq_fifo.sv
`timescale 1ns/1ps
module cmq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [W-1:0]       din,
  input  logic               pop,
  output logic [W-1:0]       dout,
  output logic               full,
  output logic               empty,
  output logic [DEPTH-1:0]   q_vld,
  output logic [DEPTH*W-1:0] q_all
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rd_p];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int off;
      off = (i >= int'(rd_p)) ? i - int'(rd_p) : i + DEPTH - int'(rd_p);
      q_vld[i] = off < int'(cnt);
      q_all[i*W +: W] = mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= nxt(wr_p);
      if (pop)  rd_p <= nxt(rd_p);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= din;
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/cmq_exec.sv
`timescale 1ns/1ps
module cmq_exec #(
  parameter int W   = 8,
  parameter int LAT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         avail,
  input  logic [W-1:0] din,
  output logic         pop,
  output logic         active,
  output logic         start,
  output logic         fin,
  output logic [W-1:0] cur
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  assign pop = avail && !active;
  assign fin = active && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      start  <= 1'b0;
      cnt    <= '0;
      cur    <= '0;
    end else begin
      start <= pop;
      if (pop) begin
        active <= 1'b1;
        cur    <= din;
        cnt    <= CW'(LAT);
      end else if (active) begin
        if (fin) active <= 1'b0;
        else     cnt <= cnt - CW'(1);
      end
    end
  end

  // R5
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fin) |=> (active && $stable(cur)));
endmodule

// File: rtl/cmq_front.sv
`timescale 1ns/1ps
module cmq_front #(
  parameter int N_CPU    = 2,
  parameter int QDEPTH   = 4,
  parameter int AW       = 32,
  parameter int WAYS     = 8,
  parameter int EXEC_LAT = 6,
  parameter int WDOG_CYC = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [N_CPU-1:0]                   cpu_req,
  input  logic [N_CPU-1:0]                   cpu_we,
  input  logic [N_CPU*3-1:0]                 cpu_sel,
  input  logic [N_CPU*32-1:0]                cpu_wdata,
  output logic [N_CPU-1:0]                   cpu_ack,
  output logic [N_CPU*32-1:0]                cpu_rdata,
  output logic                               ex_start,
  output logic [$clog2(N_CPU>1?N_CPU:2)-1:0] ex_cpu,
  output logic [2:0]                         ex_cmd,
  output logic [1:0]                         ex_region,
  output logic [1:0]                         ex_target,
  output logic [AW-1:0]                      ex_addr,
  output logic [AW-1:0]                      ex_size,
  output logic [WAYS-1:0]                    ex_ways,
  output logic                               ex_done
);
  import cmq_pkg::*;

  localparam int CPUW   = $clog2(N_CPU > 1 ? N_CPU : 2);
  localparam int O_WAYS = 0;
  localparam int O_SIZE = O_WAYS + WAYS;
  localparam int O_ADDR = O_SIZE + AW;
  localparam int O_TGT  = O_ADDR + AW;
  localparam int O_RGN  = O_TGT + 2;
  localparam int O_CMD  = O_RGN + 2;
  localparam int O_NOTE = O_CMD + 3;
  localparam int O_CPU  = O_NOTE + 1;
  localparam int EW     = O_CPU + CPUW;

  // per-processor decoded strobes
  logic [N_CPU-1:0] mode_wr, addr_wr, size_wr, ways_wr, setres_rd;
  logic [N_CPU-1:0] stat_wr, prim_wr, prim_rd;

  // arbiter
  logic            own_vld, commit, wd_fire;
  logic [CPUW-1:0] own_id;
  logic [31:0]     mode_q;
  logic [AW-1:0]   addr_q, size_q;
  logic [WAYS-1:0] ways_q;
  logic [N_CPU-1:0] fail_evt;

  // queue and executor
  logic              q_push, q_pop, q_full, q_empty;
  logic [EW-1:0]     q_din, q_dout, cur;
  logic [QDEPTH-1:0] q_vld;
  logic [QDEPTH*EW-1:0] q_all;
  logic              ex_active, ex_fin;
  logic              drained, pfb_any;

  cmq_arbiter #(.N_CPU(N_CPU), .AW(AW), .WAYS(WAYS), .WDOG_CYC(WDOG_CYC)) u_arb (
    .clk, .rst_n, .mode_wr, .addr_wr, .size_wr, .ways_wr, .setres_rd,
    .wdata(cpu_wdata), .own_vld, .own_id, .mode_q, .addr_q, .size_q, .ways_q,
    .fail_evt, .commit, .wd_fire
  );

  // field gating on commit: unused fields travel as zero
  always_comb begin
    q_din = '0;
    q_din[O_CPU +: CPUW] = own_id;
    q_din[O_NOTE]        = f_note(mode_q);
    q_din[O_CMD +: 3]    = f_cmd(mode_q);
    q_din[O_RGN +: 2]    = f_region(mode_q);
    q_din[O_TGT +: 2]    = f_target(mode_q);
    if (f_region(mode_q) == RGN_RANGE) begin
      q_din[O_ADDR +: AW] = addr_q;
      q_din[O_SIZE +: AW] = size_q;
    end
    if (f_target(mode_q) == TGT_WAY) q_din[O_WAYS +: WAYS] = ways_q;
  end

  assign q_push = commit && !q_full;

  cmq_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
    .clk, .rst_n, .push(q_push), .din(q_din), .pop(q_pop), .dout(q_dout),
    .full(q_full), .empty(q_empty), .q_vld, .q_all
  );

  cmq_exec #(.W(EW), .LAT(EXEC_LAT)) u_exec (
    .clk, .rst_n, .avail(!q_empty), .din(q_dout), .pop(q_pop),
    .active(ex_active), .start(ex_start), .fin(ex_fin), .cur
  );

  assign ex_done   = ex_fin;
  assign ex_cpu    = cur[O_CPU +: CPUW];
  assign ex_cmd    = cur[O_CMD +: 3];
  assign ex_region = cur[O_RGN +: 2];
  assign ex_target = cur[O_TGT +: 2];
  assign ex_addr   = cur[O_ADDR +: AW];
  assign ex_size   = cur[O_SIZE +: AW];
  assign ex_ways   = cur[O_WAYS +: WAYS];

  assign drained = q_empty && !ex_active;

  always_comb begin
    pfb_any = ex_active && (cur[O_CMD +: 3] == CMD_PFBUF);
    for (int i = 0; i < QDEPTH; i++) begin
      if (q_vld[i] && q_all[i*EW + O_CMD +: 3] == CMD_PFBUF) pfb_any = 1'b1;
    end
  end

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    sel_e        sel;
    logic        acc, wr, rd, is_owner, busy, drain_ok;
    logic        err_q, ef_q, dpend_q;
    logic [3:0]  dcode_q;
    logic [31:0] rdw, wd;

    assign sel      = sel_e'(cpu_sel[g*3 +: 3]);
    assign wd       = cpu_wdata[g*32 +: 32];
    assign drain_ok = (dcode_q == PRIM_SYNC) ? drained : !pfb_any;
    assign cpu_ack[g] = !(cpu_req[g] && !cpu_we[g] && sel == SEL_PRIM && dpend_q && !drain_ok);
    assign acc      = cpu_req[g] && cpu_ack[g];
    assign wr       = acc && cpu_we[g];
    assign rd       = acc && !cpu_we[g];
    assign is_owner = own_vld && own_id == CPUW'(g);

    assign mode_wr[g]   = wr && sel == SEL_MODE;
    assign addr_wr[g]   = wr && sel == SEL_ADDR;
    assign size_wr[g]   = wr && sel == SEL_SIZE;
    assign ways_wr[g]   = wr && sel == SEL_WAYS;
    assign stat_wr[g]   = wr && sel == SEL_STAT;
    assign prim_wr[g]   = wr && sel == SEL_PRIM;
    assign setres_rd[g] = rd && sel == SEL_SETRES;
    assign prim_rd[g]   = rd && sel == SEL_PRIM;

    always_comb begin
      busy = ex_active && cur[O_CPU +: CPUW] == CPUW'(g);
      for (int i = 0; i < QDEPTH; i++) begin
        if (q_vld[i] && q_all[i*EW + O_CPU +: CPUW] == CPUW'(g)) busy = 1'b1;
      end
    end

    always_comb begin
      case (sel)
        SEL_MODE:   rdw = mode_q;
        SEL_ADDR:   rdw = 32'(addr_q);
        SEL_SIZE:   rdw = 32'(size_q);
        SEL_WAYS:   rdw = 32'(ways_q);
        SEL_SETRES: rdw = is_owner ? f_setres(q_full, 1'b0) : f_setres(1'b0, err_q);
        SEL_STAT:   rdw = {29'd0, ef_q, err_q, busy};
        SEL_PRIM:   rdw = {28'd0, dcode_q};
        default:    rdw = '0;
      endcase
    end
    assign cpu_rdata[g*32 +: 32] = rdw;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        err_q   <= 1'b0;
        ef_q    <= 1'b0;
        dpend_q <= 1'b0;
        dcode_q <= '0;
      end else begin
        if (fail_evt[g] || (wd_fire && is_owner)) err_q <= 1'b1;
        else if (setres_rd[g])                    err_q <= 1'b0;

        if (ex_fin && cur[O_NOTE] && cur[O_CPU +: CPUW] == CPUW'(g)) ef_q <= 1'b1;
        else if (stat_wr[g] && wd[2])                                  ef_q <= 1'b0;

        if (prim_wr[g] && (wd[3:0] == PRIM_SYNC || wd[3:0] == PRIM_PFB)) begin
          dpend_q <= 1'b1;
          dcode_q <= wd[3:0];
        end else if (prim_rd[g]) begin
          dpend_q <= 1'b0;
        end
      end
    end

    // R8
    note_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_fin && cur[O_NOTE] && cur[O_CPU +: CPUW] == CPUW'(g)) |=> ef_q);

    // R3
    fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_evt[g] |=> err_q);

    // R9
    drain_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prim_rd[g] && dpend_q) |=> !dpend_q);
  end
endmodule

// File: tb/test_cmq_front.sv
`timescale 1ns/1ps
module test_cmq_front;
  import cmq_pkg::*;

  localparam int NC  = 2;
  localparam int QD  = 4;
  localparam int LAT = 16;
  localparam int WD  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    req = '0, we = '0;
  logic [NC*3-1:0]  sel = '0;
  logic [NC*32-1:0] wdata = '0;
  wire  [NC-1:0]    ack;
  wire  [NC*32-1:0] rdata;
  wire        ex_start, ex_done;
  wire  [0:0] ex_cpu;
  wire  [2:0] ex_cmd;
  wire  [1:0] ex_region, ex_target;
  wire  [31:0] ex_addr, ex_size;
  wire  [7:0]  ex_ways;

  int checks = 0, fails = 0, cyc = 0, last_start = -1000;
  logic [79:0] exp_q[$];
  logic [NC-1:0] exp_ef = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmq_front #(.N_CPU(NC), .QDEPTH(QD), .AW(32), .WAYS(8), .EXEC_LAT(LAT), .WDOG_CYC(WD)) i_cmq_front (
    .clk, .rst_n, .cpu_req(req), .cpu_we(we), .cpu_sel(sel), .cpu_wdata(wdata),
    .cpu_ack(ack), .cpu_rdata(rdata), .ex_start, .ex_cpu, .ex_cmd, .ex_region,
    .ex_target, .ex_addr, .ex_size, .ex_ways, .ex_done
  );

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected executor view of a committed command
  function automatic logic [79:0] model_entry(input int c, input logic [31:0] m,
      input logic [31:0] a, input logic [31:0] s, input logic [7:0] w);
    logic [1:0] rg, tg;
    logic [31:0] ea, es;
    logic [7:0] ew;
    rg = m[18:17];
    tg = m[22:21];
    ea = 32'd0; es = 32'd0; ew = 8'd0;
    if (rg == 2'd0) begin ea = a; es = s; end
    if (tg == 2'd2) ew = w;
    return {c[0], m[2:0], rg, tg, ea, es, ew};
  endfunction

  always @(negedge clk) begin
    if (rst_n && ex_start) begin
      logic [79:0] act;
      act = {ex_cpu, ex_cmd, ex_region, ex_target, ex_addr, ex_size, ex_ways};
      check(cyc - last_start >= LAT + 1, "R5 start spacing", 80'(cyc - last_start), 80'(LAT + 1));
      last_start = cyc;
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected command", act, 80'd0);
      else begin
        logic [79:0] e;
        e = exp_q.pop_front();
        check(act == e, "R1/R5/R6 executor fields", act, e);
      end
    end
  end

  task automatic acc(input int c, input bit w, input sel_e s, input logic [31:0] d,
                     output logic [31:0] rd, output int waits);
    @(negedge clk);
    req[c] = 1'b1; we[c] = w; sel[c*3 +: 3] = s; wdata[c*32 +: 32] = d;
    waits = 0;
    #1;
    while (!ack[c]) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = rdata[c*32 +: 32];
    @(posedge clk);
    #1 req[c] = 1'b0;
  endtask

  task automatic wr1(input int c, input sel_e s, input logic [31:0] d);
    logic [31:0] r; int n;
    acc(c, 1'b1, s, d, r, n);
  endtask

  task automatic rd1(input int c, input sel_e s, output logic [31:0] r);
    int n;
    acc(c, 1'b0, s, 32'd0, r, n);
  endtask

  task automatic reg_op(input int c, input logic [31:0] m, input logic [31:0] a,
                        input logic [31:0] s, input logic [7:0] w, output logic [31:0] res);
    wr1(c, SEL_MODE, m);
    if (m[18:17] == 2'd0) begin
      wr1(c, SEL_ADDR, a);
      wr1(c, SEL_SIZE, s);
    end
    if (m[22:21] == 2'd2) wr1(c, SEL_WAYS, {24'd0, w});
    rd1(c, SEL_SETRES, res);
    if (res == 32'd0) begin
      exp_q.push_back(model_entry(c, m, a, s, w));
      if (m[15]) exp_ef[c] = 1'b1;
    end
  endtask

  task automatic drain(output int waits);
    logic [31:0] r;
    wr1(0, SEL_PRIM, 32'h8);
    acc(0, 1'b0, SEL_PRIM, 32'd0, r, waits);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog expired act=hung exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, r1;
    int n, seed;
    seed = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    for (int c = 0; c < NC; c++) begin
      rd1(c, SEL_STAT, r);
      check(r == 0, "R7 reset status", 80'(r), 80'd0);
      rd1(c, SEL_SETRES, r);
      check(r == 0, "R3 reset set-result", 80'(r), 80'd0);
    end
    acc(0, 1'b0, SEL_PRIM, 32'd0, r, n);
    check(n == 0, "R9 primitive read idle", 80'(n), 80'd0);

    // R1 R6: range command with notice from cpu0
    reg_op(0, 32'h0000_8001, 32'h1000_0040, 32'h0000_0200, 8'h3C, r);
    check(r == 0, "R4 accept range", 80'(r), 80'd0);
    rd1(0, SEL_STAT, r);
    check(r[0] == 1'b1, "R7 busy while queued", 80'(r), 80'd1);
    drain(n);
    check(n > 0, "R9 sync stalls", 80'(n), 80'd1);
    check(exp_q.size() == 0, "R9 drained after sync", 80'(exp_q.size()), 80'd0);
    rd1(0, SEL_STAT, r);
    check(r == 32'h4, "R8 completion flag set", 80'(r), 80'h4);
    wr1(0, SEL_STAT, 32'h4);
    rd1(0, SEL_STAT, r);
    check(r == 32'h0, "R8 completion cleared", 80'(r), 80'h0);
    exp_ef[0] = 1'b0;

    // R6: all-region, way-targeted; stale addr/size must not pass
    reg_op(1, (32'd1 << 17) | (32'd2 << 21) | 32'd5, 32'hDEAD_0000, 32'h40, 8'hA5, r);
    check(r == 0, "R6 accept way-targeted", 80'(r), 80'd0);
    drain(n);

    // R2 R3: contention, non-owner writes ignored
    wr1(0, SEL_MODE, 32'h0000_0001);
    wr1(1, SEL_MODE, 32'h0000_0002);
    rd1(1, SEL_STAT, r);
    check(r[1] == 1'b1, "R7 error bit in status", 80'(r), 80'h2);
    wr1(0, SEL_ADDR, 32'h0000_1000);
    wr1(1, SEL_ADDR, 32'h0000_9000);
    wr1(0, SEL_SIZE, 32'h0000_0080);
    rd1(0, SEL_SETRES, r);
    check(r == 0, "R2 owner commits", 80'(r), 80'd0);
    if (r == 0) exp_q.push_back(model_entry(0, 32'h1, 32'h1000, 32'h80, 8'd0));
    rd1(1, SEL_SETRES, r);
    check(r == 32'h1, "R3 loser sees error", 80'(r), 80'h1);
    rd1(1, SEL_SETRES, r);
    check(r == 32'h0, "R3 error cleared by read", 80'(r), 80'h0);
    drain(n);

    // R2: simultaneous claim, lower index wins
    fork
      wr1(0, SEL_MODE, (32'd1 << 17) | 32'd2);
      wr1(1, SEL_MODE, (32'd1 << 17) | 32'd1);
    join
    rd1(1, SEL_SETRES, r1);
    rd1(0, SEL_SETRES, r);
    check(r == 0, "R2 simultaneous winner cpu0", 80'(r), 80'd0);
    check(r1 == 32'h1, "R2 simultaneous loser cpu1", 80'(r1), 80'h1);
    if (r == 0) exp_q.push_back(model_entry(0, (32'd1 << 17) | 32'd2, 0, 0, 0));
    drain(n);

    // R4: fill the queue
    for (int k = 0; k < QD + 1; k++) begin
      reg_op(0, (32'd1 << 17) | 32'(k % 3), 0, 0, 0, r);
      check(r == 0, "R4 accept while room", 80'(r), 80'd0);
    end
    reg_op(0, (32'd1 << 17) | 32'd2, 0, 0, 0, r);
    check(r == 32'h2, "R4 full returns bit1", 80'(r), 80'h2);
    rd1(0, SEL_STAT, r);
    check(r[0] == 1'b1, "R7 busy with full queue", 80'(r), 80'h1);
    drain(n);
    rd1(0, SEL_STAT, r);
    check(r[0] == 1'b0, "R7 idle after drain", 80'(r), 80'h0);

    // R9: code 9 waits only for prefetch-to-buffer
    reg_op(1, 32'h0000_0001, 32'h200, 32'h40, 0, r);
    wr1(1, SEL_PRIM, 32'h9);
    acc(1, 1'b0, SEL_PRIM, 32'd0, r, n);
    check(n == 0, "R9 code9 no pfb pending", 80'(n), 80'd0);
    check(r == 32'h9, "R9 primitive readback", 80'(r), 80'h9);
    reg_op(1, 32'h0000_0004, 32'h400, 32'h40, 0, r);
    wr1(1, SEL_PRIM, 32'h9);
    acc(1, 1'b0, SEL_PRIM, 32'd0, r, n);
    check(n > 0, "R9 code9 waits for pfb", 80'(n), 80'd1);
    drain(n);

    // R8: clear write lands on the finishing edge
    wr1(0, SEL_STAT, 32'h4);
    reg_op(0, (32'd1 << 15) | (32'd1 << 17) | 32'd2, 0, 0, 0, r);
    do @(negedge clk); while (!ex_start);
    repeat (LAT - 2) @(negedge clk);
    wr1(0, SEL_STAT, 32'h4);
    rd1(0, SEL_STAT, r);
    check(r[2] == 1'b1, "R8 set wins over clear", 80'(r), 80'h4);
    wr1(0, SEL_STAT, 32'h4);
    rd1(0, SEL_STAT, r);
    check(r[2] == 1'b0, "R8 clear after collision", 80'(r), 80'h0);
    drain(n);

    // R10: abandoned claim released by watchdog
    wr1(0, SEL_MODE, 32'h0000_0001);
    repeat (WD + 3) @(negedge clk);
    reg_op(1, (32'd1 << 17) | 32'd2, 0, 0, 0, r);
    check(r == 0, "R10 claim freed", 80'(r), 80'd0);
    rd1(0, SEL_STAT, r);
    check(r[1] == 1'b1, "R10 holder error flag", 80'(r), 80'h2);
    rd1(0, SEL_SETRES, r);
    check(r == 32'h1, "R10 holder set-result error", 80'(r), 80'h1);
    drain(n);

    // random traffic
    wr1(0, SEL_STAT, 32'h4);
    wr1(1, SEL_STAT, 32'h4);
    exp_ef = '0;
    for (int k = 0; k < 60; k++) begin
      int c;
      logic [31:0] m, a, s;
      logic [7:0] w;
      c = $urandom % NC;
      m = ((($urandom % 2) == 0) ? 32'd0 : (32'd1 << 15)) | (32'($urandom % 3) << 17)
        | (32'($urandom % 3) << 21) | 32'($urandom % 8);
      a = $urandom; s = $urandom; w = 8'($urandom);
      reg_op(c, m, a, s, w, r);
      while (r == 32'h2) begin
        repeat (5) @(negedge clk);
        reg_op(c, m, a, s, w, r);
      end
      if (r != 0) check(1'b0, "R3 unexpected error", 80'(r), 80'd0);
      repeat ($urandom % 4) @(negedge clk);
    end
    drain(n);
    check(exp_q.size() == 0, "R5 all random commands ran", 80'(exp_q.size()), 80'd0);
    for (int c = 0; c < NC; c++) begin
      rd1(c, SEL_STAT, r);
      check(r == {29'd0, exp_ef[c], 2'b00}, "R7/R8 random status", 80'(r), 80'({exp_ef[c], 2'b00}));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule